// File: doc/BRIEF.md
# Timestamp Clock Target Comparator

This block runs a 64-bit time counter that advances by a programmable increment on every clock. It compares that counter against a 64-bit target value in every cycle. When the two are equal, a sticky timer interrupt is raised. The target is then moved to its next value, chosen by a mode bit:

- **Reload mode:** the target is loaded from a value the host has already written.
- **Add mode:** the same register is used as an interval and added to the target. This gives a periodic event.

The host reaches the block through a 32-bit register port. The 64-bit time counter, target and reload/add registers are each written as two 32-bit halves. A register changes only when its second half arrives, and the two halves may come in either order.

The timer interrupt is cleared in either of two ways:

- The host writes a one to the status bit.
- A GPIO pin that is configured as an input stays high long enough to pass a pulse-width filter.

The combined event output is the OR of every interrupt source, each qualified by its own enable.

Top module: `clock_target_cmp`

Register word addresses on `regAddr`:

| Address | Register |
|---|---|
| 0 | Time counter, low half |
| 1 | Time counter, high half |
| 2 | Target, low half |
| 3 | Target, high half |
| 4 | Reload/add, low half |
| 5 | Reload/add, high half |
| 6 | Control |
| 7 | Status |
| 8 | Increment |

Control register fields:

| Bits | Field |
|---|---|
| 0 | Mode: 1 = reload, 0 = add |
| 1 | Timer interrupt enable |
| 8 and up | External source enables |
| 16 and up | GPIO input enables |

## Requirements
- R1: The time counter adds the increment register (address 8, reset value 1) on every clock and wraps modulo 2^64 without saturating.
- R2: When the time counter equals the target, status bit 0 (the timer interrupt) reads 1 from the next cycle on and stays set until it is cleared.
- R3: With control bit 0 at 1, a match loads the target from the reload/add register on the following clock.
- R4: With control bit 0 at 0, a match replaces the target with target plus the reload/add register, modulo 2^64, on the following clock.
- R5: The time counter, target and reload/add registers each commit only when both halves have been written (low half at the even address, high half at the odd one), in either order. A lone half, or a rewrite of the same half, leaves the register unchanged, and the last data written to each half is used.
- R6: A host write that sets the time counter to a value equal to the current target produces a match, with the interrupt and the target update, in the next cycle.
- R7: Writing 1 to status bit 0 clears the timer interrupt. A match in the same cycle wins, and the bit stays 1.
- R8: A GPIO pin whose input enable (control bit 16 + pin index) is set clears the timer interrupt once it has been high for FILTER_CYCLES (default 9) consecutive synchronized cycles. Shorter pulses, and pins whose enable is clear, have no effect.
- R9: `eventOut` equals (timer interrupt AND control bit 1) OR the OR over i of (`extIrq[i]` AND control bit 8 + i).
- R10: After reset the time counter is 0, the target is all ones, the reload/add register, control and status are 0, and the increment is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word address for reads and writes |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| gpioPin | input | NUM_GPIO | GPIO inputs, active high, asynchronous |
| extIrq | input | EXT_SRCS | Other interrupt sources, level |
| timeNow | output | 64 | Current time counter |
| eventOut | output | 1 | Combined, enabled interrupt event |
| timerIrq | output | 1 | Raw sticky timer interrupt |

## Verification
The assertions assume that the host issues at most one register write per cycle. They also assume that a target write and a match do not land in the same cycle, because the host write takes precedence there and the match-driven update properties exclude that case.

The stimulus meets these assumptions in several ways:

- It writes one register per cycle.
- It places targets far ahead of the running counter.
- It drives GPIO pins only from the bench clock's negative edge.

The one deliberate coincidence, a clear write landing in a match cycle, is arranged by polling the counter output.

// File: rtl/ctc_pkg.sv
package ctc_pkg;

  localparam logic [3:0] ADDR_TIME_LO = 4'd0;
  localparam logic [3:0] ADDR_TIME_HI = 4'd1;
  localparam logic [3:0] ADDR_TGT_LO  = 4'd2;
  localparam logic [3:0] ADDR_TGT_HI  = 4'd3;
  localparam logic [3:0] ADDR_RLD_LO  = 4'd4;
  localparam logic [3:0] ADDR_RLD_HI  = 4'd5;
  localparam logic [3:0] ADDR_CTRL    = 4'd6;
  localparam logic [3:0] ADDR_STAT    = 4'd7;
  localparam logic [3:0] ADDR_INCR    = 4'd8;

  localparam int CTRL_MODE_BIT = 0;
  localparam int CTRL_TEN_BIT  = 1;
  localparam int CTRL_EXT_LSB  = 8;
  localparam int CTRL_GPIO_LSB = 16;

  // staged 64-bit registers, index g lives at word addresses 2g / 2g+1
  localparam int NUM_STAGED = 3;
  localparam int STG_TIME   = 0;
  localparam int STG_TGT    = 1;
  localparam int STG_RLD    = 2;

  typedef struct packed {
    logic timeLoad;
    logic tgtLoad;
    logic rldLoad;
    logic irqClr;
  } strobe_t;

endpackage

// File: rtl/ctc_gpio_filter.sv
module ctc_gpio_filter #(
  parameter int FILTER_CYCLES = 9
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  input  logic enIn,
  output logic clrPulse
);
  localparam int CNT_W = $clog2(FILTER_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FILTER_CYCLES);
  localparam logic [CNT_W-1:0] CNT_FIRE = CNT_W'(FILTER_CYCLES - 1);

  logic syncA, syncQ;
  logic [CNT_W-1:0] highCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncQ <= 1'b0;
    end else begin
      syncA <= pinIn;
      syncQ <= syncA;
    end
  end

  // counts consecutive high samples, holds at the limit until the pin drops
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highCnt <= '0;
    end else if (!enIn || !syncQ) begin
      highCnt <= '0;
    end else if (highCnt != CNT_MAX) begin
      highCnt <= highCnt + 1'b1;
    end
  end

  assign clrPulse = enIn && syncQ && (highCnt == CNT_FIRE);

  // R8: one clear per high period
  a_r8_single_clear: assert property (@(posedge clk) disable iff (!rstN)
    clrPulse |=> !clrPulse);

  // R8: a clear only follows a pin that was already high
  a_r8_pin_was_high: assert property (@(posedge clk) disable iff (!rstN)
    clrPulse |-> $past(syncQ));

endmodule

// File: rtl/ctc_ctrl.sv
module ctc_ctrl
  import ctc_pkg::*;
#(
  parameter int INC_W    = 8,
  parameter int EXT_SRCS = 2,
  parameter int NUM_GPIO = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [3:0]          regAddr,
  input  logic [31:0]         regWrData,
  output logic [31:0]         regRdData,
  input  logic                gpioClr,
  input  logic [63:0]         timeNow,
  input  logic [63:0]         target,
  input  logic [63:0]         reloadVal,
  input  logic                timerIrq,
  output strobe_t             strb,
  output logic [63:0]         loadVal,
  output logic                reloadMode,
  output logic                timerEn,
  output logic [EXT_SRCS-1:0] extEn,
  output logic [NUM_GPIO-1:0] gpioInEn,
  output logic [INC_W-1:0]    incr
);

  logic [NUM_STAGED-1:0] commit;
  logic [63:0]           commitVal [NUM_STAGED];

  for (genvar g = 0; g < NUM_STAGED; g++) begin : g_stage
    localparam logic [3:0] LO_ADDR = 4'(2 * g);
    localparam logic [3:0] HI_ADDR = 4'(2 * g + 1);
    logic [31:0] loHold, hiHold;
    logic        loSeen, hiSeen;
    logic        wrLo, wrHi;

    assign wrLo = regWrEn && (regAddr == LO_ADDR);
    assign wrHi = regWrEn && (regAddr == HI_ADDR);
    assign commit[g] = (wrLo && hiSeen) || (wrHi && loSeen);
    assign commitVal[g] = wrLo ? {hiHold, regWrData} : {regWrData, loHold};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        loHold <= '0;
        hiHold <= '0;
        loSeen <= 1'b0;
        hiSeen <= 1'b0;
      end else if (commit[g]) begin
        loSeen <= 1'b0;
        hiSeen <= 1'b0;
      end else if (wrLo) begin
        loHold <= regWrData;
        loSeen <= 1'b1;
      end else if (wrHi) begin
        hiHold <= regWrData;
        hiSeen <= 1'b1;
      end
    end

    // R5: nothing commits without a write to this register pair
    a_r5_commit_on_write: assert property (@(posedge clk) disable iff (!rstN)
      commit[g] |-> (regWrEn && (regAddr[3:1] == LO_ADDR[3:1])));
  end

  always_comb begin
    loadVal = '0;
    for (int i = 0; i < NUM_STAGED; i++) begin
      if (commit[i]) loadVal = commitVal[i];
    end
  end

  logic wrCtrl, wrStat, wrIncr;
  assign wrCtrl = regWrEn && (regAddr == ADDR_CTRL);
  assign wrStat = regWrEn && (regAddr == ADDR_STAT);
  assign wrIncr = regWrEn && (regAddr == ADDR_INCR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadMode <= 1'b0;
      timerEn    <= 1'b0;
      extEn      <= '0;
      gpioInEn   <= '0;
      incr       <= INC_W'(1);
    end else begin
      if (wrCtrl) begin
        reloadMode <= regWrData[CTRL_MODE_BIT];
        timerEn    <= regWrData[CTRL_TEN_BIT];
        extEn      <= regWrData[CTRL_EXT_LSB +: EXT_SRCS];
        gpioInEn   <= regWrData[CTRL_GPIO_LSB +: NUM_GPIO];
      end
      if (wrIncr) incr <= regWrData[INC_W-1:0];
    end
  end

  assign strb.timeLoad = commit[STG_TIME];
  assign strb.tgtLoad  = commit[STG_TGT];
  assign strb.rldLoad  = commit[STG_RLD];
  assign strb.irqClr   = (wrStat && regWrData[0]) || gpioClr;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_TIME_LO: regRdData = timeNow[31:0];
      ADDR_TIME_HI: regRdData = timeNow[63:32];
      ADDR_TGT_LO:  regRdData = target[31:0];
      ADDR_TGT_HI:  regRdData = target[63:32];
      ADDR_RLD_LO:  regRdData = reloadVal[31:0];
      ADDR_RLD_HI:  regRdData = reloadVal[63:32];
      ADDR_CTRL: begin
        regRdData[CTRL_MODE_BIT]               = reloadMode;
        regRdData[CTRL_TEN_BIT]                = timerEn;
        regRdData[CTRL_EXT_LSB +: EXT_SRCS]    = extEn;
        regRdData[CTRL_GPIO_LSB +: NUM_GPIO]   = gpioInEn;
      end
      ADDR_STAT:    regRdData[0] = timerIrq;
      ADDR_INCR:    regRdData[INC_W-1:0] = incr;
      default:      regRdData = '0;
    endcase
  end

  // R5: at most one staged register commits per cycle
  a_r5_one_commit: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(commit));

endmodule

// File: rtl/ctc_datapath.sv
module ctc_datapath
  import ctc_pkg::*;
#(
  parameter int INC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [63:0]      loadVal,
  input  logic             reloadMode,
  input  logic [INC_W-1:0] incr,
  output logic [63:0]      timeNow,
  output logic [63:0]      target,
  output logic [63:0]      reloadVal,
  output logic             timerIrq,
  output logic             matchHit
);

  logic [63:0] nextTarget;

  assign matchHit   = (timeNow == target);
  assign nextTarget = reloadMode ? reloadVal : (target + reloadVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeNow   <= '0;
      target    <= '1;
      reloadVal <= '0;
      timerIrq  <= 1'b0;
    end else begin
      timeNow <= strb.timeLoad ? loadVal : (timeNow + 64'(incr));
      if (strb.tgtLoad)   target <= loadVal;
      else if (matchHit)  target <= nextTarget;
      if (strb.rldLoad)   reloadVal <= loadVal;
      if (matchHit)          timerIrq <= 1'b1;
      else if (strb.irqClr)  timerIrq <= 1'b0;
    end
  end

  a_r1_advance: assert property (@(posedge clk) disable iff (!rstN)
    !strb.timeLoad |=> timeNow == $past(timeNow) + 64'($past(incr)));

  a_r2_match_sets_irq: assert property (@(posedge clk) disable iff (!rstN)
    matchHit |=> timerIrq);

  a_r3_reload: assert property (@(posedge clk) disable iff (!rstN)
    (matchHit && reloadMode && !strb.tgtLoad) |=> target == $past(reloadVal));

  a_r4_add: assert property (@(posedge clk) disable iff (!rstN)
    (matchHit && !reloadMode && !strb.tgtLoad)
      |=> target == $past(target) + $past(reloadVal));

  a_r5_target_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!matchHit && !strb.tgtLoad) |=> $stable(target));

  a_r7_clear: assert property (@(posedge clk) disable iff (!rstN)
    (!matchHit && strb.irqClr) |=> !timerIrq);

  a_r2_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (timerIrq && !strb.irqClr) |=> timerIrq);

endmodule

// File: rtl/clock_target_cmp.sv
module clock_target_cmp
  import ctc_pkg::*;
#(
  parameter int INC_W         = 8,
  parameter int EXT_SRCS      = 2,
  parameter int NUM_GPIO      = 2,
  parameter int FILTER_CYCLES = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [3:0]          regAddr,
  input  logic [31:0]         regWrData,
  output logic [31:0]         regRdData,
  input  logic [NUM_GPIO-1:0] gpioPin,
  input  logic [EXT_SRCS-1:0] extIrq,
  output logic [63:0]         timeNow,
  output logic                eventOut,
  output logic                timerIrq
);

  strobe_t             strb;
  logic [63:0]         loadVal, target, reloadVal;
  logic                reloadMode, timerEn, matchHit;
  logic [EXT_SRCS-1:0] extEn;
  logic [NUM_GPIO-1:0] gpioInEn, pinClr;
  logic [INC_W-1:0]    incr;

  for (genvar p = 0; p < NUM_GPIO; p++) begin : g_pin
    ctc_gpio_filter #(.FILTER_CYCLES(FILTER_CYCLES)) u_filter (
      .clk      (clk),
      .rstN     (rstN),
      .pinIn    (gpioPin[p]),
      .enIn     (gpioInEn[p]),
      .clrPulse (pinClr[p])
    );
  end

  ctc_ctrl #(.INC_W(INC_W), .EXT_SRCS(EXT_SRCS), .NUM_GPIO(NUM_GPIO)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .gpioClr    (|pinClr),
    .timeNow    (timeNow),
    .target     (target),
    .reloadVal  (reloadVal),
    .timerIrq   (timerIrq),
    .strb       (strb),
    .loadVal    (loadVal),
    .reloadMode (reloadMode),
    .timerEn    (timerEn),
    .extEn      (extEn),
    .gpioInEn   (gpioInEn),
    .incr       (incr)
  );

  ctc_datapath #(.INC_W(INC_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .loadVal    (loadVal),
    .reloadMode (reloadMode),
    .incr       (incr),
    .timeNow    (timeNow),
    .target     (target),
    .reloadVal  (reloadVal),
    .timerIrq   (timerIrq),
    .matchHit   (matchHit)
  );

  assign eventOut = (timerIrq && timerEn) || (|(extIrq & extEn));

  // R9: a disabled timer interrupt never reaches the event output alone
  a_r9_masked: assert property (@(posedge clk) disable iff (!rstN)
    (!timerEn && ((extIrq & extEn) == '0)) |-> !eventOut);

  // R6: a time load equal to the target raises the interrupt one cycle later
  a_r6_load_match: assert property (@(posedge clk) disable iff (!rstN)
    (strb.timeLoad && !strb.tgtLoad && (loadVal == target)) |=> ##1 timerIrq);

endmodule

// File: tb/clock_target_cmp_bench.sv
`timescale 1ns/1ps
module clock_target_cmp_bench;

  localparam logic [3:0] A_TLO = 4'd0, A_THI = 4'd1, A_GLO = 4'd2, A_GHI = 4'd3;
  localparam logic [3:0] A_RLO = 4'd4, A_RHI = 4'd5, A_CTL = 4'd6, A_STA = 4'd7;
  localparam logic [3:0] A_INC = 4'd8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [1:0]  gpioPin = '0;
  logic [1:0]  extIrq = '0;
  logic [63:0] timeNow;
  logic        eventOut, timerIrq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  clock_target_cmp u_clock_target_cmp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .gpioPin(gpioPin),
    .extIrq(extIrq), .timeNow(timeNow), .eventOut(eventOut), .timerIrq(timerIrq)
  );

  // vector: {write, addr, data-or-expected, requirement number}
  localparam int NV = 20;
  localparam logic [40:0] VECS [NV] = '{
    {1'b0, A_GLO, 32'hFFFF_FFFF, 4'd10},  // R10 target reset low
    {1'b0, A_GHI, 32'hFFFF_FFFF, 4'd10},  // R10 target reset high
    {1'b0, A_RLO, 32'h0000_0000, 4'd10},  // R10 reload reset
    {1'b0, A_CTL, 32'h0000_0000, 4'd10},  // R10 control reset
    {1'b0, A_STA, 32'h0000_0000, 4'd10},  // R10 status reset
    {1'b0, A_INC, 32'h0000_0001, 4'd10},  // R10 increment reset
    {1'b1, A_GLO, 32'h1111_0000, 4'd5},   // R5 low half only
    {1'b0, A_GLO, 32'hFFFF_FFFF, 4'd5},   // R5 not yet committed
    {1'b1, A_GHI, 32'h0000_2222, 4'd5},   // R5 second half commits
    {1'b0, A_GLO, 32'h1111_0000, 4'd5},
    {1'b0, A_GHI, 32'h0000_2222, 4'd5},
    {1'b1, A_RHI, 32'h0000_000A, 4'd5},   // R5 high half first
    {1'b0, A_RHI, 32'h0000_0000, 4'd5},
    {1'b1, A_RLO, 32'h0000_000B, 4'd5},
    {1'b0, A_RHI, 32'h0000_000A, 4'd5},
    {1'b0, A_RLO, 32'h0000_000B, 4'd5},
    {1'b1, A_GHI, 32'h0000_0005, 4'd5},   // R5 same half twice
    {1'b1, A_GHI, 32'h0000_0006, 4'd5},
    {1'b0, A_GHI, 32'h0000_2222, 4'd5},
    {1'b1, A_GLO, 32'h0000_0007, 4'd5}
  };

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  task automatic wr64(input logic [3:0] loA, input logic [63:0] v);
    wr(loA, v[31:0]);
    wr(loA + 4'd1, v[63:32]);
  endtask

  task automatic rdTarget(output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(A_GLO, lo);
    rd(A_GHI, hi);
    v = {hi, lo};
  endtask

  task automatic waitTime(input logic [63:0] v);
    while (timeNow !== v) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finishRun();
    end
  end

  initial begin
    logic [31:0] v32;
    logic [63:0] v64, t0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 time near zero", 64'(timeNow < 64'd4), 64'd1);
    check("R10 irq", 64'(timerIrq), 64'd0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i][40]) begin
        wr(VECS[i][39:36], VECS[i][35:4]);
      end else begin
        rd(VECS[i][39:36], v32);
        checks++;
        if (v32 !== VECS[i][35:4]) begin
          fails++;
          $display("FAIL R%0d vector %0d: got %h expected %h", VECS[i][3:0], i, v32, VECS[i][35:4]);
        end
      end
    end
    rdTarget(v64);
    check("R5 last-written halves", v64, 64'h0000_0006_0000_0007);

    // R1 increment and wrap
    wr(A_INC, 32'd3);
    t0 = timeNow;
    @(negedge clk);
    check("R1 advance by 3", timeNow, t0 + 64'd3);
    wr64(A_TLO, 64'hFFFF_FFFF_FFFF_FFFE);
    check("R1 loaded time", timeNow, 64'hFFFF_FFFF_FFFF_FFFE);
    @(negedge clk);
    check("R1 wrap", timeNow, 64'd1);
    wr(A_INC, 32'd1);

    // R2 / R4 periodic add mode
    wr(A_CTL, 32'h2);
    wr64(A_RLO, 64'd100);
    wr64(A_GLO, 64'd1000);
    wr64(A_TLO, 64'd990);
    check("R2 irq idle", 64'(timerIrq), 64'd0);
    waitTime(64'd1000);
    @(negedge clk);
    check("R2 irq set", 64'(timerIrq), 64'd1);
    check("R9 event enabled", 64'(eventOut), 64'd1);
    rdTarget(v64);
    check("R4 add target", v64, 64'd1100);

    // R7 clear and same-cycle priority
    wr(A_STA, 32'h1);
    check("R7 w1c", 64'(timerIrq), 64'd0);
    waitTime(64'd1200);
    wr(A_STA, 32'h1);
    check("R7 match wins", 64'(timerIrq), 64'd1);
    rdTarget(v64);
    check("R4 second period", v64, 64'd1300);

    // R3 reload mode
    wr(A_CTL, 32'h3);
    wr64(A_RLO, 64'd5000);
    waitTime(64'd1300);
    @(negedge clk);
    rdTarget(v64);
    check("R3 reload target", v64, 64'd5000);

    // R6 time write equal to target
    wr64(A_RLO, 64'd7777);
    wr(A_STA, 32'h1);
    check("R7 cleared", 64'(timerIrq), 64'd0);
    wr64(A_TLO, 64'd5000);
    @(negedge clk);
    check("R6 irq on load", 64'(timerIrq), 64'd1);
    rdTarget(v64);
    check("R6 target update", v64, 64'd7777);

    // R9 masking
    wr(A_CTL, 32'h1);
    check("R9 masked", 64'(eventOut), 64'd0);
    wr(A_CTL, 32'h3);

    // R8 pin not enabled
    gpioPin[0] = 1'b1;
    repeat (20) @(negedge clk);
    gpioPin[0] = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 disabled pin", 64'(timerIrq), 64'd1);
    wr(A_CTL, 32'h0001_0003);
    gpioPin[0] = 1'b1;
    repeat (6) @(negedge clk);
    gpioPin[0] = 1'b0;
    repeat (10) @(negedge clk);
    check("R8 short pulse", 64'(timerIrq), 64'd1);
    gpioPin[0] = 1'b1;
    repeat (20) @(negedge clk);
    gpioPin[0] = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 long pulse", 64'(timerIrq), 64'd0);

    // R9 external source
    extIrq = 2'b01;
    @(negedge clk);
    check("R9 ext disabled", 64'(eventOut), 64'd0);
    wr(A_CTL, 32'h0001_0103);
    check("R9 ext enabled", 64'(eventOut), 64'd1);
    extIrq = 2'b00;
    #1;
    check("R9 ext gone", 64'(eventOut), 64'd0);

    // R4 target wrap
    wr(A_CTL, 32'h2);
    wr64(A_RLO, 64'h20);
    wr64(A_GLO, 64'hFFFF_FFFF_FFFF_FFF0);
    wr64(A_TLO, 64'hFFFF_FFFF_FFFF_FFE0);
    waitTime(64'hFFFF_FFFF_FFFF_FFF0);
    @(negedge clk);
    rdTarget(v64);
    check("R4 target wraps", v64, 64'h10);
    waitTime(64'h10);
    @(negedge clk);
    rdTarget(v64);
    check("R4 after time wrap", v64, 64'h30);

    finishRun();
  end

endmodule